// File: doc/BRIEF.md
# Bidirectional Shift Register with Parallel Load

This block is a register of configurable width. On each rising clock edge it does one of four things, chosen by a two-bit mode input: it keeps its value, moves every bit one place toward the LSB, moves every bit one place toward the MSB, or takes a new word from a parallel input. Two serial inputs supply the bit that enters at the open end of each shift direction. The whole register is driven onto a parallel output at all times.

A surrounding datapath uses it in one of three ways. As a serializer, it loads a word and then shifts it out. As a deserializer, it shifts bits in and then reads the full word. It can also hold a word while other logic works. A synchronous, active-high reset clears the register, and reset wins over any mode.

Top module: `bidir_shifter`

## Requirements
- R1: With `mode` = 2'b00 and `rst` low, the register keeps its value across the clock edge. Changes on `parIn`, `fillMsb` and `fillLsb` have no effect on it.
- R2: With `mode` = 2'b01 and `rst` low, the register shifts right (toward bit 0). Bit i takes the old bit i+1, the old bit 0 is dropped, and the MSB takes `fillMsb`.
- R3: With `mode` = 2'b10 and `rst` low, the register shifts left (toward the MSB). Bit i takes the old bit i-1, the old MSB is dropped, and bit 0 takes `fillLsb`.
- R4: With `mode` = 2'b11 and `rst` low, the register takes the value of `parIn` on the clock edge.
- R5: When `rst` is high at a rising edge, the register is all zeros after that edge. Reset acts only at clock edges.
- R6: Reset takes priority over every mode value, including load. At most one register action is selected in any cycle.
- R7: `regOut` is `WIDTH` bits wide, with `WIDTH` = 8 by default. It always shows the full register contents.
- R8: The mode may change on every cycle. Each edge applies only the mode present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| mode | input | 2 | 00 hold, 01 shift right, 10 shift left, 11 load |
| parIn | input | WIDTH | Word taken in load mode |
| fillMsb | input | 1 | Bit entering the MSB on a right shift |
| fillLsb | input | 1 | Bit entering bit 0 on a left shift |
| regOut | output | WIDTH | Current register contents |

## Verification
The assertions check, on every cycle, that the next value follows the mode sampled at the previous edge: hold, right shift with its fill bit, left shift with its fill bit, or load. They also check that reset zeroes the register and that the decoded actions never overlap. Only the bench scenarios show end-to-end behaviour. These include a mode that changes on every cycle, long shift runs that empty the register completely, reset asserted together with a load, and inputs toggled during hold with no effect at the output. All of these are compared with an independent model.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_RIGHT = 2'b01,
    MODE_LEFT  = 2'b10,
    MODE_LOAD  = 2'b11
  } mode_e;

  // Strobes from the decoder to the datapath; none set means hold.
  typedef struct packed {
    logic clear;
    logic load;
    logic shiftRight;
    logic shiftLeft;
  } strobe_t;
endpackage

// File: rtl/shifter_ctrl.sv
module shifter_ctrl
  import shifter_pkg::*;
(
  input  logic       rst,
  input  logic [1:0] mode,
  output strobe_t    stb
);
  always_comb begin
    stb = '0;
    if (rst) begin
      stb.clear = 1'b1;           // reset overrides every mode
    end else begin
      unique case (mode_e'(mode))
        MODE_RIGHT: stb.shiftRight = 1'b1;
        MODE_LEFT:  stb.shiftLeft  = 1'b1;
        MODE_LOAD:  stb.load       = 1'b1;
        default:    stb = '0;
      endcase
    end
  end
endmodule

// File: rtl/shifter_dp.sv
module shifter_dp
  import shifter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  strobe_t          stb,
  input  logic [WIDTH-1:0] parIn,
  input  logic             fillMsb,
  input  logic             fillLsb,
  output logic [WIDTH-1:0] q
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] nxt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic rightSrc;
    logic leftSrc;
    if (i == MSB) begin : g_rtop
      assign rightSrc = fillMsb;
    end else begin : g_rmid
      assign rightSrc = q[i+1];
    end
    if (i == 0) begin : g_lbot
      assign leftSrc = fillLsb;
    end else begin : g_lmid
      assign leftSrc = q[i-1];
    end
    assign nxt[i] = stb.load       ? parIn[i] :
                    stb.shiftRight ? rightSrc :
                    stb.shiftLeft  ? leftSrc  : q[i];
  end

  always_ff @(posedge clk) begin
    if (stb.clear) q <= '0;
    else           q <= nxt;
  end
endmodule

// File: rtl/bidir_shifter.sv
module bidir_shifter
  import shifter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] parIn,
  input  logic             fillMsb,
  input  logic             fillLsb,
  output logic [WIDTH-1:0] regOut
);
  strobe_t stb;

  shifter_ctrl u_ctrl (
    .rst  (rst),
    .mode (mode),
    .stb  (stb)
  );

  shifter_dp #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .stb     (stb),
    .parIn   (parIn),
    .fillMsb (fillMsb),
    .fillLsb (fillLsb),
    .q       (regOut)
  );
endmodule

// File: rtl/bidir_shifter_chk.sv
module bidir_shifter_chk
  import shifter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] parIn,
  input logic             fillMsb,
  input logic             fillLsb,
  input logic [WIDTH-1:0] regOut,
  input strobe_t          stb
);
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_HOLD |=> $stable(regOut)); // R1
  AST_RIGHT_SHIFT: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_RIGHT |=> regOut == {$past(fillMsb), $past(regOut[WIDTH-1:1])}); // R2
  AST_LEFT_SHIFT: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_LEFT |=> regOut == {$past(regOut[WIDTH-2:0]), $past(fillLsb)}); // R3
  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_LOAD |=> regOut == $past(parIn)); // R4
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> regOut == '0); // R5
  AST_ONE_ACTION: assert property (@(posedge clk)
    $onehot0(stb) && (rst == stb.clear)); // R6
endmodule

bind bidir_shifter bidir_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mode    (mode),
  .parIn   (parIn),
  .fillMsb (fillMsb),
  .fillLsb (fillLsb),
  .regOut  (regOut),
  .stb     (stb)
);

// File: tb/bidir_shifter_tb.sv
module bidir_shifter_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] parIn = '0;
  logic         fillMsb = 1'b0;
  logic         fillLsb = 1'b0;
  logic [W-1:0] regOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [W-1:0] val;
    string        req;
  } item_t;
  item_t sbq[$];
  logic [W-1:0] model = '0;

  always #5 clk = ~clk;

  bidir_shifter #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .mode(mode), .parIn(parIn),
    .fillMsb(fillMsb), .fillLsb(fillLsb), .regOut(regOut)
  );

  // Driver: set inputs at the falling edge and queue the expected value after the next rise.
  task automatic step(input logic r, input logic [1:0] m, input logic [W-1:0] p,
                      input logic fm, input logic fl, input string req);
    item_t it;
    @(negedge clk);
    rst = r; mode = m; parIn = p; fillMsb = fm; fillLsb = fl;
    if (r)               model = '0;
    else if (m == 2'b01) model = {fm, model[W-1:1]};
    else if (m == 2'b10) model = {model[W-2:0], fl};
    else if (m == 2'b11) model = p;
    it.val = model; it.req = req;
    sbq.push_back(it);
  endtask

  // Monitor: sample 2 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        checks++;
        if (regOut !== it.val) begin
          errors++;
          $display("FAIL %s: regOut=%h expected=%h", it.req, regOut, it.val);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: finished=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R7: output width
    checks++;
    if ($bits(regOut) != 8) begin
      errors++;
      $display("FAIL R7: width=%0d expected=8", $bits(regOut));
    end
    // R5: reset state
    step(1, 2'b00, '0, 0, 0, "R5");
    step(1, 2'b11, 8'hFF, 1, 1, "R5");
    // R4: load
    step(0, 2'b11, 8'hA5, 0, 0, "R4");
    // R1: hold while other inputs toggle
    step(0, 2'b00, 8'h3C, 1, 1, "R1");
    step(0, 2'b00, 8'hFF, 0, 1, "R1");
    // R2: right shifts, fill ones then zeros, enough to empty the register
    for (int i = 0; i < 4; i++) step(0, 2'b01, 8'h00, 1, 0, "R2");
    for (int i = 0; i < 9; i++) step(0, 2'b01, 8'hFF, 0, 1, "R2");
    // R3: left shifts with alternating fill
    step(0, 2'b11, 8'h81, 0, 0, "R4");
    for (int i = 0; i < 10; i++) step(0, 2'b10, 8'h00, 0, logic'(i[0]), "R3");
    // R6: reset during load wins
    step(0, 2'b11, 8'h7E, 0, 0, "R4");
    step(1, 2'b11, 8'hC3, 1, 1, "R6");
    step(0, 2'b00, 8'h55, 1, 1, "R1");
    // R8: mode changes every cycle
    for (int i = 0; i < 200; i++)
      step(0, 2'(i), 8'($urandom), 1'($urandom), 1'($urandom), "R8");
    for (int i = 0; i < 300; i++)
      step(1'($urandom_range(0, 15) == 0), 2'($urandom), 8'($urandom),
           1'($urandom), 1'($urandom), "R8");
    step(0, 2'b00, '0, 0, 0, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule